// File: doc/BRIEF.md
# RTC Bus Access and Interrupt Control

This block is the bus-facing slice of a real-time clock. It sits between a simple synchronous register bus and the clock's counting core. A single enable bit, cleared by chip reset, guards every other register: until software sets it, bus writes to the clock's registers are dropped and reads of them return zero. The enable register itself can always be accessed, so software can open the block after reset.

Behind the guard are three registers. An 8-bit increment-select register picks which time fields raise an interrupt when they count. An 8-bit alarm mask removes fields from the alarm comparison. A 2-bit pending register records the two interrupt sources, and its bits clear when a one is written to them. The counting core supplies one increment pulse and one equality flag for each field. This block turns them into pending bits and drives one interrupt line.

Two reset inputs are used. The chip reset clears only the enable bit. A separate power-on reset clears the select, mask and pending state. This matches the battery-backed part of a clock, which keeps its contents across chip resets.

Top module: `rtc_bus_ctrl`

## Requirements
- R1: The enable register is at address 0, with the enable in bit 0. Chip reset (`rst_n` low) clears it. It can be written and read whatever its value, and its bits 31:1 read as zero.
- R2: While the enable is 0, bus writes to addresses 1 to 3 leave the pending, increment-select and alarm-mask registers unchanged.
- R3: While the enable is 0, a read of any address other than 0 returns zero.
- R4: While the enable is 1, the increment-select register (address 2, bits 7:0) and the alarm-mask register (address 3, bits 7:0) read back the value written to them. Their upper bits read as zero, and addresses 4 to 7 read as zero.
- R5: The pending register is at address 1. Bit 0 is the increment source and bit 1 is the alarm source. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R6: Pending bit 0 is set in the cycle after an `inc_evt` pulse on any field whose increment-select bit is 1. Pulses on fields whose select bit is 0 have no effect.
- R7: The alarm match is true when every field whose mask bit is 0 has its `field_eq` flag high and at least one field is unmasked. Pending bit 1 is set in the cycle after the match goes from false to true.
- R8: If a source sets a pending bit in the same cycle that a write of 1 clears it, the bit stays set.
- R9: `irq` is high exactly when at least one pending bit is set.
- R10: Chip reset leaves the pending, increment-select and alarm-mask registers unchanged. Only `por_n` low clears them to zero.
- R11: Events set pending bits whether or not the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Chip reset, active low; clears only the enable |
| por_n | input | 1 | Power-on reset, active low; clears the retained registers |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while a read is selected |
| inc_evt | input | 8 | One-cycle increment pulse for each time field |
| field_eq | input | 8 | Equality flag for each alarm field |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that gated writes leave the retained registers unchanged and that gated reads return zero. They also check that a selected increment pulse or an alarm edge always leaves its pending bit set, that a clear with no competing event drops bit 0, and that the chip reset clears the enable. Other behaviour can only be shown by the bench's scenarios:
- the arithmetic of the alarm match, checked over all 256 masks;
- the increment selection, checked over every select and pulse pair;
- read-back of the registers;
- whether the registers keep their contents across a chip reset;
- the read-and-write-back clearing pattern, which needs a sequence of bus transfers.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int NFIELD = 8;
    localparam int NSRC   = 2;
    localparam int NREG   = 4;

    // Bit positions of the two interrupt sources in the pending register.
    localparam int SRC_INC = 0;
    localparam int SRC_ALM = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG    = 3'd0,
        A_PEND   = 3'd1,
        A_INCSEL = 3'd2,
        A_AMASK  = 3'd3
    } reg_addr_e;
endpackage

// File: rtl/rtc_access_gate.sv
module rtc_access_gate
    import rtc_bus_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NREG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic          wbit0,
    output logic          en_o,
    output logic [NR-1:0] wr_stb_o,
    output logic          rd_ok_o
);
    typedef struct packed {
        logic en;
    } gate_t;

    gate_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (bus_sel && bus_wr && (bus_addr == AW'(A_CFG)))
            nxt_d.en = wbit0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // The enable register itself is never gated; every other strobe is.
    for (genvar i = 0; i < NR; i++) begin : g_stb
        assign wr_stb_o[i] = bus_sel && bus_wr && (bus_addr == AW'(i))
                             && ((i == 0) || cur_q.en);
    end

    assign rd_ok_o = bus_sel && !bus_wr && cur_q.en;
    assign en_o    = cur_q.en;
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
    import rtc_bus_pkg::*;
#(
    parameter int NF = NFIELD
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          we_incsel,
    input  logic          we_amask,
    input  logic [NF-1:0] wdata,
    output logic [NF-1:0] incsel_o,
    output logic [NF-1:0] amask_o
);
    typedef struct packed {
        logic [NF-1:0] incsel;
        logic [NF-1:0] amask;
    } cfg_t;

    cfg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (we_incsel) nxt_d.incsel = wdata;
        if (we_amask)  nxt_d.amask  = wdata;
    end

    // Retained domain: only the power-on reset clears it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign incsel_o = cur_q.incsel;
    assign amask_o  = cur_q.amask;
endmodule

// File: rtl/rtc_irq_core.sv
module rtc_irq_core
    import rtc_bus_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [NF-1:0] inc_evt,
    input  logic [NF-1:0] field_eq,
    input  logic [NF-1:0] incsel,
    input  logic [NF-1:0] amask,
    input  logic          clr_stb,
    input  logic [NS-1:0] clr_bits,
    output logic [NS-1:0] pend_o,
    output logic          alarm_fire_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [NS-1:0] pend;
        logic          match_prev;
    } irq_t;

    irq_t cur_q, nxt_d;
    logic [NS-1:0] set_v;
    logic [NS-1:0] clr_v;
    logic          inc_hit;
    logic          match_now;
    logic          fire;

    always_comb begin
        inc_hit   = |(inc_evt & incsel);
        match_now = (&(field_eq | amask)) && !(&amask);
        fire      = match_now && !cur_q.match_prev;

        set_v          = '0;
        set_v[SRC_INC] = inc_hit;
        set_v[SRC_ALM] = fire;
        clr_v          = clr_stb ? clr_bits : '0;

        nxt_d            = cur_q;
        nxt_d.match_prev = match_now;
        // A setting event takes precedence over a simultaneous clear.
        nxt_d.pend       = (cur_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pend_o       = cur_q.pend;
    assign alarm_fire_o = fire;
    assign irq_o        = |cur_q.pend;
endmodule

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
    import rtc_bus_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NF = NFIELD,
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NF-1:0] inc_evt,
    input  logic [NF-1:0] field_eq,
    output logic          irq
);
    logic [NREG-1:0] wr_stb;
    logic            en_w;
    logic            rd_ok;
    logic [NF-1:0]   incsel_w;
    logic [NF-1:0]   amask_w;
    logic [NS-1:0]   pend_w;
    logic            alarm_fire_w;
    logic            unused_hi;

    assign unused_hi = ^bus_wdata[DW-1:NF];

    rtc_access_gate #(.AW(AW), .NR(NREG)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wbit0    (bus_wdata[0]),
        .en_o     (en_w),
        .wr_stb_o (wr_stb),
        .rd_ok_o  (rd_ok)
    );

    rtc_cfg_regs #(.NF(NF)) u_cfg (
        .clk       (clk),
        .por_n     (por_n),
        .we_incsel (wr_stb[A_INCSEL]),
        .we_amask  (wr_stb[A_AMASK]),
        .wdata     (bus_wdata[NF-1:0]),
        .incsel_o  (incsel_w),
        .amask_o   (amask_w)
    );

    rtc_irq_core #(.NF(NF), .NS(NS)) u_irq (
        .clk          (clk),
        .por_n        (por_n),
        .inc_evt      (inc_evt),
        .field_eq     (field_eq),
        .incsel       (incsel_w),
        .amask        (amask_w),
        .clr_stb      (wr_stb[A_PEND]),
        .clr_bits     (bus_wdata[NS-1:0]),
        .pend_o       (pend_w),
        .alarm_fire_o (alarm_fire_w),
        .irq_o        (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == AW'(A_CFG)) begin
                bus_rdata = DW'(en_w);
            end else if (rd_ok) begin
                case (bus_addr)
                    AW'(A_PEND):   bus_rdata = DW'(pend_w);
                    AW'(A_INCSEL): bus_rdata = DW'(incsel_w);
                    AW'(A_AMASK):  bus_rdata = DW'(amask_w);
                    default:       bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_bus_ctrl_chk.sv
module rtc_bus_ctrl_chk #(
    parameter int AW = 3,
    parameter int DW = 32,
    parameter int NF = 8,
    parameter int NS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          por_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [NF-1:0] inc_evt,
    input logic          irq,
    input logic          en,
    input logic [NS-1:0] pend,
    input logic [NF-1:0] incsel,
    input logic [NF-1:0] amask,
    input logic          alarm_fire
);
    p_cfg_reset_r1: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> !en);

    p_gate_write_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (bus_sel && bus_wr && !en && bus_addr != '0)
        |=> ($stable(incsel) && $stable(amask)));

    p_read_gate_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (bus_sel && !bus_wr && !en && bus_addr != '0) |-> (bus_rdata == '0));

    p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (bus_sel && bus_wr && en && bus_addr == AW'(1) && bus_wdata[0]
         && !(|(inc_evt & incsel))) |=> !pend[0]);

    p_inc_set_r6: assert property (@(posedge clk) disable iff (!por_n)
        (|(inc_evt & incsel)) |=> pend[0]);

    p_alarm_set_r7: assert property (@(posedge clk) disable iff (!por_n)
        alarm_fire |=> pend[1]);

    p_event_wins_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ((|(inc_evt & incsel)) && bus_sel && bus_wr && en && bus_addr == AW'(1))
        |=> pend[0]);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(irq) |-> $past((|(inc_evt & incsel)) || alarm_fire));
endmodule

bind rtc_bus_ctrl rtc_bus_ctrl_chk #(.AW(AW), .DW(DW), .NF(NF), .NS(NS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .inc_evt    (inc_evt),
    .irq        (irq),
    .en         (en_w),
    .pend       (pend_w),
    .incsel     (incsel_w),
    .amask      (amask_w),
    .alarm_fire (alarm_fire_w)
);

// File: tb/rtc_bus_ctrl_test.sv
module rtc_bus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  inc_evt = '0;
    logic [7:0]  field_eq = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rtc_bus_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .inc_evt   (inc_evt),
        .field_eq  (field_eq),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic pulse_inc(input logic [7:0] v);
        @(negedge clk); inc_evt = v;
        @(posedge clk); #1 inc_evt = '0;
    endtask

    // Drive one non-matching cycle, then the given flags for one cycle.
    task automatic alarm_try(input logic [7:0] e);
        @(negedge clk); field_eq = '0;
        @(negedge clk); field_eq = e;
        @(posedge clk); #1 field_eq = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 por_n = 1; rst_n = 1;

        // Reset state: gated, nothing pending
        rd(3'd0, d); check("R1 cfg after reset", d, 0);
        check("R9 irq after reset", {31'd0, irq}, 0);
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), d); check("R3 gated read", d, 0);
        end

        // Event while disabled, then writes while disabled
        alarm_try(8'hFF);
        check("R11 alarm captured while disabled", {31'd0, irq}, 1);
        wr(3'd2, 32'hFF); wr(3'd3, 32'hFF); wr(3'd1, 32'h3);
        check("R2 gated clear ignored", {31'd0, irq}, 1);
        rd(3'd1, d); check("R3 read while disabled", d, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R1 enable reads 1, reserved 0", d, 1);
        rd(3'd1, d); check("R2 pending unchanged", d, 2);
        rd(3'd2, d); check("R2 incsel unchanged", d, 0);
        rd(3'd3, d); check("R2 amask unchanged", d, 0);

        // W1C semantics
        wr(3'd1, 32'h0); rd(3'd1, d); check("R5 write zero keeps", d, 2);
        wr(3'd1, 32'h2); rd(3'd1, d); check("R5 write one clears", d, 0);
        check("R9 irq low when clear", {31'd0, irq}, 0);

        // Read-back sweep
        for (int v = 0; v < 256; v += 17) begin
            wr(3'd2, 32'hABCD_0000 | 32'(v)); rd(3'd2, d); check("R4 incsel readback", d, 32'(v));
            wr(3'd3, 32'h1234_5600 | 32'(255 - v)); rd(3'd3, d); check("R4 amask readback", d, 32'(255 - v));
        end
        for (int a = 4; a < 8; a++) begin
            rd(3'(a), d); check("R4 reserved address", d, 0);
        end

        // Increment select sweep
        wr(3'd3, 32'hFF);
        for (int s = 0; s < 8; s++) begin
            wr(3'd2, 32'(1 << s));
            for (int b = 0; b < 8; b++) begin
                wr(3'd1, 32'h3);
                pulse_inc(8'(1 << b));
                rd(3'd1, d); check("R6 increment select", d, (s == b) ? 1 : 0);
                check("R9 irq follows pending", {31'd0, irq}, (s == b) ? 1 : 0);
            end
        end
        wr(3'd2, 32'h0); wr(3'd1, 32'h3);
        pulse_inc(8'hFF); rd(3'd1, d); check("R6 no select no set", d, 0);

        // Alarm mask sweep
        for (int m = 0; m < 256; m++) begin
            logic [7:0] mm, unm, low;
            logic [7:0] pats [3];
            mm = 8'(m); unm = ~mm; low = unm & (~unm + 8'd1);
            pats[0] = 8'hFF; pats[1] = unm; pats[2] = unm & ~low;
            wr(3'd3, 32'(m));
            for (int p = 0; p < 3; p++) begin
                logic exp;
                exp = (&(pats[p] | mm)) && (mm != 8'hFF);
                alarm_try(pats[p]);
                rd(3'd1, d); check("R7 alarm match", d, {30'd0, exp, 1'b0});
                wr(3'd1, 32'h2);
            end
        end

        // Event beats clear; alarm bit cleared in same write
        wr(3'd3, 32'h0); alarm_try(8'hFF);
        wr(3'd2, 32'h04);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'h3; inc_evt = 8'h04;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_wdata = '0; inc_evt = '0;
        rd(3'd1, d); check("R8 event wins over clear", d, 1);

        // Chip reset retains registers
        wr(3'd2, 32'h5A); wr(3'd3, 32'h3C);
        @(negedge clk) rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        rd(3'd0, d); check("R1 chip reset clears enable", d, 0);
        rd(3'd2, d); check("R3 gated after chip reset", d, 0);
        check("R10 irq kept across chip reset", {31'd0, irq}, 1);
        wr(3'd0, 32'h1);
        rd(3'd2, d); check("R10 incsel kept", d, 32'h5A);
        rd(3'd3, d); check("R10 amask kept", d, 32'h3C);
        rd(3'd1, d); check("R10 pending kept", d, 1);

        // Power-on reset clears retained state
        @(negedge clk) por_n = 0; rst_n = 0;
        repeat (2) @(posedge clk);
        #1 por_n = 1; rst_n = 1;
        wr(3'd0, 32'h1);
        rd(3'd1, d); check("R10 por clears pending", d, 0);
        rd(3'd2, d); check("R10 por clears incsel", d, 0);
        rd(3'd3, d); check("R10 por clears amask", d, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule